// File: doc/BRIEF.md
# Iterative Odd-Even Transposition Sorter

The block sorts a fixed set of `NUM_WORDS` unsigned words of `WORD_W` bits each. All words arrive together on a flat parallel bus and are captured by a one-cycle start pulse. The design does not build the full transposition network. It keeps a single row of `NUM_WORDS/2` compare-and-swap cells and reuses that row on every clock. An input switch network routes each register pair to the row, and an output switch network puts the results back in the right slots before they are written into the word registers. The phase alternates between even pairs (0-1, 2-3, …) and odd pairs (1-2, 3-4, …), and each clock performs one full compare-exchange phase.

A three-state controller runs the sort. ST_IDLE is the state after reset. A start pulse in any state moves it to ST_RUN, which reloads the words and restarts the phase sequence. ST_RUN moves to ST_DONE in either of two cases:
- no cell has exchanged its pair in two phases in a row, or
- the number of phases performed reaches `NUM_WORDS`.

ST_DONE holds the sorted words and raises `done_o` until the next start pulse. `NUM_WORDS` must be even and at least 2.

Top module: `oddeven_sorter`

## Requirements
- R1: After reset `done_o` is 0 and every word of `dout_o` is 0.
- R2: A start pulse sampled at a clock edge loads `din_i` into the word registers at that edge. Word i is at bits [i*WORD_W +: WORD_W]. At that same edge `done_o` goes low.
- R3: When `done_o` is high, `dout_o` is in ascending unsigned order: word 0 is the smallest and word `NUM_WORDS-1` is the largest.
- R4: When `done_o` is high, `dout_o` holds exactly the loaded words: the same values, duplicates included, in sorted order.
- R5: Equal neighbours never count as an exchange, so a set made entirely of equal words completes after exactly 2 phases.
- R6: An input that is already in ascending order raises `done_o` after exactly 2 phases. The sorter stops once two consecutive phases perform no exchange.
- R7: `done_o` rises no more than `NUM_WORDS` clock edges after the loading edge, for any input.
- R8: While `done_o` is high and no start pulse arrives, `done_o` stays high and `dout_o` stays unchanged, whatever happens on `din_i`.
- R9: A start pulse during ST_RUN discards the sort in progress and sorts the newly presented words.
- R10: The first phase after a load is the even phase. A single out-of-order pair at positions 1-2 completes in 4 phases, and a single out-of-order pair at positions 0-1 completes in 3 phases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load-and-start pulse, one cycle |
| din_i | input | NUM_WORDS*WORD_W | Words to sort, word i at [i*WORD_W +: WORD_W] |
| dout_o | output | NUM_WORDS*WORD_W | Word registers, sorted when done is high |
| done_o | output | 1 | High in ST_DONE |

## Verification
The hardest behaviour to reach from the ports is the exact moment of early termination. It depends on which phase comes first and on whether the two quiet phases happen back to back. Random data almost always needs many phases, so it never isolates this. The bench therefore uses directed sets where exactly one pair is out of order: one at an even boundary and one at an odd boundary. It also uses fully sorted and all-equal sets. The stop latency of each of these sets is known in advance. Random sets with narrow value ranges, which produce many duplicates, are added alongside, together with a restart in mid-sort.

// File: rtl/ots_pkg.sv
package ots_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } ots_state_e;

    typedef enum logic {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } ots_phase_e;
endpackage

// File: rtl/ots_cmp_cell.sv
module ots_cmp_cell #(
    parameter int WORD_W = 32
) (
    input  logic              en,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic [WORD_W-1:0] lo,
    output logic [WORD_W-1:0] hi,
    output logic              swapped
);
    // Strictly greater: ties are left in place and flag nothing.
    always_comb begin
        swapped = en && (a > b);
        lo      = swapped ? b : a;
        hi      = swapped ? a : b;
    end
endmodule

// File: rtl/ots_exch_row.sv
module ots_exch_row
    import ots_pkg::*;
#(
    parameter int NUM_WORDS = 128,
    parameter int WORD_W    = 32
) (
    input  logic [NUM_WORDS*WORD_W-1:0] cur,
    input  ots_phase_e                  phase,
    output logic [NUM_WORDS*WORD_W-1:0] nxt,
    output logic                        no_change
);
    localparam int HALF = NUM_WORDS / 2;

    logic [WORD_W-1:0] lo_w [HALF];
    logic [WORD_W-1:0] hi_w [HALF];
    logic [HALF-1:0]   swp;

    // Input switch network: select the pair each cell sees in this phase.
    for (genvar k = 0; k < HALF; k++) begin : g_cell
        logic [WORD_W-1:0] a_sel;
        logic [WORD_W-1:0] b_sel;
        logic              en_sel;

        if (k < HALF - 1) begin : g_mid
            always_comb begin
                if (phase == PH_ODD) begin
                    a_sel = cur[(2*k+1)*WORD_W +: WORD_W];
                    b_sel = cur[(2*k+2)*WORD_W +: WORD_W];
                end else begin
                    a_sel = cur[(2*k)*WORD_W +: WORD_W];
                    b_sel = cur[(2*k+1)*WORD_W +: WORD_W];
                end
                en_sel = 1'b1;
            end
        end else begin : g_last
            // The last cell has no partner pair in the odd phase; it idles.
            always_comb begin
                a_sel  = cur[(2*k)*WORD_W +: WORD_W];
                b_sel  = cur[(2*k+1)*WORD_W +: WORD_W];
                en_sel = (phase == PH_EVEN);
            end
        end

        ots_cmp_cell #(.WORD_W(WORD_W)) i_cell (
            .en      (en_sel),
            .a       (a_sel),
            .b       (b_sel),
            .lo      (lo_w[k]),
            .hi      (hi_w[k]),
            .swapped (swp[k])
        );
    end

    // Output switch network: put cell results back into word slots.
    always_comb begin
        nxt = cur;
        if (phase == PH_EVEN) begin
            for (int k = 0; k < HALF; k++) begin
                nxt[(2*k)*WORD_W   +: WORD_W] = lo_w[k];
                nxt[(2*k+1)*WORD_W +: WORD_W] = hi_w[k];
            end
        end else begin
            for (int k = 0; k < HALF - 1; k++) begin
                nxt[(2*k+1)*WORD_W +: WORD_W] = lo_w[k];
                nxt[(2*k+2)*WORD_W +: WORD_W] = hi_w[k];
            end
        end
    end

    assign no_change = ~|swp;
endmodule

// File: rtl/ots_ctrl.sv
module ots_ctrl
    import ots_pkg::*;
#(
    parameter int NUM_WORDS = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       no_change,
    output ots_phase_e phase,
    output logic       load,
    output logic       advance,
    output logic       done
);
    localparam int CW = $clog2(NUM_WORDS + 1);
    localparam logic [CW-1:0] LAST_ITER = CW'(NUM_WORDS - 1);

    ots_state_e    state_q, state_d;
    logic [CW-1:0] iter_q;
    logic [1:0]    quiet_q;
    logic          finish;

    assign finish = (no_change && (quiet_q == 2'd1)) || (iter_q == LAST_ITER);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN: begin
                if (start)       state_d = ST_RUN;
                else if (finish) state_d = ST_DONE;
            end
            ST_DONE: if (start) state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Phase, iteration and quiet-phase counters.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iter_q  <= '0;
            quiet_q <= '0;
            phase   <= PH_EVEN;
        end else if (start) begin
            iter_q  <= '0;
            quiet_q <= '0;
            phase   <= PH_EVEN;
        end else if (state_q == ST_RUN) begin
            iter_q  <= iter_q + 1'b1;
            phase   <= (phase == PH_EVEN) ? PH_ODD : PH_EVEN;
            if (!no_change)             quiet_q <= 2'd0;
            else if (quiet_q != 2'd2)   quiet_q <= quiet_q + 2'd1;
        end
    end

    always_comb begin
        load    = start;
        advance = (state_q == ST_RUN) && !start;
        done    = (state_q == ST_DONE);
    end
endmodule

// File: rtl/oddeven_sorter.sv
module oddeven_sorter
    import ots_pkg::*;
#(
    parameter int NUM_WORDS = 128,
    parameter int WORD_W    = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [NUM_WORDS*WORD_W-1:0] din_i,
    output logic [NUM_WORDS*WORD_W-1:0] dout_o,
    output logic                        done_o
);
    logic [NUM_WORDS*WORD_W-1:0] words_q;
    logic [NUM_WORDS*WORD_W-1:0] row_nxt;
    logic                        no_change;
    logic                        load;
    logic                        advance;
    ots_phase_e                  phase;

    ots_exch_row #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) i_row (
        .cur       (words_q),
        .phase     (phase),
        .nxt       (row_nxt),
        .no_change (no_change)
    );

    ots_ctrl #(.NUM_WORDS(NUM_WORDS)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_i),
        .no_change (no_change),
        .phase     (phase),
        .load      (load),
        .advance   (advance),
        .done      (done_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       words_q <= '0;
        else if (load)    words_q <= din_i;
        else if (advance) words_q <= row_nxt;
    end

    assign dout_o = words_q;
endmodule

// File: rtl/ots_chk.sv
module ots_chk #(
    parameter int NUM_WORDS = 128,
    parameter int WORD_W    = 32
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        start_i,
    input logic [NUM_WORDS*WORD_W-1:0] dout_o,
    input logic                        done_o
);
    localparam int CNW = $clog2(NUM_WORDS + 2) + 1;

    logic [CNW-1:0] run_cnt;
    logic           sorted_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  run_cnt <= '0;
        else if (start_i)                            run_cnt <= '0;
        else if (!done_o && run_cnt != {CNW{1'b1}})  run_cnt <= run_cnt + 1'b1;
    end

    always_comb begin
        sorted_ok = 1'b1;
        for (int i = 0; i < NUM_WORDS - 1; i++)
            if (dout_o[i*WORD_W +: WORD_W] > dout_o[(i+1)*WORD_W +: WORD_W])
                sorted_ok = 1'b0;
    end

    // R2
    start_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !done_o);

    // R3
    sorted_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> sorted_ok);

    // R8
    done_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(dout_o)));

    // R7
    bounded_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (run_cnt <= CNW'(NUM_WORDS)));
endmodule

bind oddeven_sorter ots_chk #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) i_ots_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .dout_o  (dout_o),
    .done_o  (done_o)
);

// File: tb/test_oddeven_sorter.sv
module test_oddeven_sorter;
    localparam int N = 128;
    localparam int W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [N*W-1:0]   din_i = '0;
    logic [N*W-1:0]   dout_o;
    logic             done_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic [W-1:0] vin [N];
    logic [W-1:0] vexp [N];
    int last_lat;

    always #2 clk = ~clk;

    oddeven_sorter #(.NUM_WORDS(N), .WORD_W(W)) i_oddeven_sorter (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .din_i(din_i), .dout_o(dout_o), .done_o(done_o)
    );

    function automatic logic [N*W-1:0] pack_in();
        logic [N*W-1:0] p;
        for (int i = 0; i < N; i++) p[i*W +: W] = vin[i];
        return p;
    endfunction

    function automatic void make_expected();
        logic [W-1:0] t;
        for (int i = 0; i < N; i++) vexp[i] = vin[i];
        for (int i = 1; i < N; i++) begin
            t = vexp[i];
            for (int j = i; j > 0; j--) begin
                if (vexp[j-1] > t) begin
                    vexp[j] = vexp[j-1];
                    vexp[j-1] = t;
                end
            end
        end
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_result(input string req);
        int bad = -1;
        for (int i = 0; i < N; i++)
            if (bad < 0 && dout_o[i*W +: W] !== vexp[i]) bad = i;
        if (bad < 0) check(1'b1, req, "sorted words", 0, 0);
        else check(1'b0, req, $sformatf("word %0d", bad),
                   longint'(dout_o[bad*W +: W]), longint'(vexp[bad]));
    endtask

    // Load vin, run to done, record latency in edges after the load edge.
    task automatic run_sort();
        logic [N*W-1:0] p;
        p = pack_in();
        @(negedge clk);
        din_i = p;
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        // R2: loaded words visible and done low right after the load edge
        check(dout_o === p, "R2", "load captures din", 0, 0);
        check(done_o === 1'b0, "R2", "done low after start", longint'(done_o), 0);
        last_lat = 0;
        while (!done_o && last_lat < N + 8) begin
            @(posedge clk);
            last_lat++;
            @(negedge clk);
        end
        make_expected();
    endtask

    task automatic fill_sorted(input int dup);
        for (int i = 0; i < N; i++) vin[i] = W'(dup ? 7 : i * 3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [N*W-1:0] held;
        void'($urandom(32'h5eed_0a11));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        check(done_o === 1'b0, "R1", "done at reset", longint'(done_o), 0);
        check(dout_o === '0, "R1", "dout at reset", 0, 0);
        rst_n = 1'b1;

        // R6: already sorted input stops after two quiet phases
        fill_sorted(0);
        run_sort();
        check(last_lat == 2, "R6", "latency sorted", last_lat, 2);
        check_result("R3");

        // R5: all equal words, ties never count as exchanges
        fill_sorted(1);
        run_sort();
        check(last_lat == 2, "R5", "latency all equal", last_lat, 2);
        check_result("R5");

        // R10: single inversion at odd boundary 1-2 -> 4 phases
        fill_sorted(0);
        vin[1] = W'(4); vin[2] = W'(3);
        run_sort();
        check(last_lat == 4, "R10", "latency odd-pair inversion", last_lat, 4);
        check_result("R10");

        // R10: single inversion at even boundary 0-1 -> 3 phases
        fill_sorted(0);
        vin[0] = W'(5); vin[1] = W'(1);
        run_sort();
        check(last_lat == 3, "R10", "latency even-pair inversion", last_lat, 3);
        check_result("R10");

        // R7: reversed order, worst case
        for (int i = 0; i < N; i++) vin[i] = W'(32'hFFFF_FFFF - i);
        run_sort();
        check(last_lat <= N, "R7", "latency reversed", last_lat, N);
        check_result("R3");

        // R4 / R3 / R7: random sets, some with narrow ranges for duplicates
        for (int t = 0; t < 24; t++) begin
            for (int i = 0; i < N; i++)
                vin[i] = (t % 3 == 0) ? W'($urandom % 8)
                       : (t % 3 == 1) ? W'($urandom % 200) : W'($urandom);
            run_sort();
            check(last_lat <= N, "R7", "latency random", last_lat, N);
            check_result("R4");
        end

        // R8: done holds, din ignored while done
        held = dout_o;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            din_i = {N{W'($urandom)}};
        end
        @(negedge clk);
        check(done_o === 1'b1, "R8", "done held", longint'(done_o), 1);
        check(dout_o === held, "R8", "dout held", 0, 0);

        // R9: restart during a running sort
        for (int i = 0; i < N; i++) vin[i] = W'(N - i);
        @(negedge clk);
        din_i = pack_in();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        check(done_o === 1'b0, "R9", "still running", longint'(done_o), 0);
        for (int i = 0; i < N; i++) vin[i] = W'($urandom % 1000);
        run_sort();
        check_result("R9");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule